// File: doc/BRIEF.md
# Coverage-Class MAC Timing Unit

This block turns a PHY mode selection (5 GHz band, CCK modulation, turbo) and an 8-bit coverage-class number into the slot time and the ACK and CTS response timeouts of a wireless MAC. Each timeout is converted from microseconds to MAC clock cycles using a clock rate fixed by the mode. A result too large for the 14-bit timeout field is refused: an error flag is raised and the previously accepted timeouts stay in force. The slot time is always taken.

A second part measures response timeouts. A transmit-done strobe for an ACK-expecting frame or a CTS-expecting frame arms a cycle counter. A response strobe stops it quietly. If the counter reaches the stored limit first, a one-cycle timeout pulse is raised, tagged with the kind of response that was awaited. New parameters are accepted only through a load strobe while no measurement is running.

Top module: `covcls_timing`

## Requirements
- R1: The cycles-per-microsecond rate is 40 when the 5 GHz bit is set, else 22 when the CCK bit is set, else 44; the turbo bit doubles it.
- R2: The base slot time is 6 us with turbo, else 20 us with CCK, else 9 us; the slot output (in us) is the base plus 3 times the coverage class.
- R3: The base SIFS is 8 us with turbo, else 16 us with 5 GHz, else 10 us; the ACK timeout in cycles is (SIFS + slot) times the rate, and the CTS timeout always equals it.
- R4: A load whose timeout T (us) satisfies floor(16383 / rate) <= T sets the error flag to 1 and leaves both timeouts unchanged; a load with a fitting T sets the flag to 0 and stores the new timeouts. The slot output is updated either way.
- R5: A load takes effect at the clock edge that samples it and only if no measurement is running; a load sampled while busy changes no output.
- R6: A transmit-done strobe sampled while idle starts a measurement (busy = 1); with no response, the timeout pulse is high for exactly one cycle, L clock edges after the arming edge, where L is the timeout in cycles. The tag output is 1 for a CTS measurement and 0 for ACK; if both strobes arrive together the ACK kind is taken.
- R7: A response strobe sampled while busy, including at the expiry edge, ends the measurement with no pulse; a response strobe while idle has no effect.
- R8: An arm strobe while busy is ignored (the running measurement keeps its kind and end time), and an arm strobe while the stored timeout is zero leaves the block idle.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_5g | input | 1 | 5 GHz band selection |
| mode_cck | input | 1 | CCK modulation selection |
| mode_turbo | input | 1 | Turbo (double clock) selection |
| cov_class | input | 8 | Coverage class number |
| load_i | input | 1 | Take new timing parameters |
| tx_ack_i | input | 1 | Transmit done, ACK awaited |
| tx_cts_i | input | 1 | Transmit done, CTS awaited |
| rsp_i | input | 1 | Awaited response received |
| slot_us_o | output | 10 | Slot time in microseconds |
| ack_cyc_o | output | 14 | ACK timeout in clock cycles |
| cts_cyc_o | output | 14 | CTS timeout in clock cycles |
| param_err_o | output | 1 | Last accepted load was out of range |
| busy_o | output | 1 | Measurement running |
| timeout_o | output | 1 | Timeout pulse |
| timeout_cts_o | output | 1 | Pulse belongs to a CTS measurement |

## Verification
The assertions assume the strobes are single-cycle synchronous levels and that the mode and coverage-class inputs are stable in the cycle a load is sampled; the bench changes them only at the falling edge and raises every strobe for one cycle. They also assume a response is only meaningful while busy; the bench sends an idle response once, on purpose, to show it is ignored. Timer checks use the shortest stored timeout so each expiry is counted edge by edge from the arming edge.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef struct packed {
    logic band5;
    logic cck;
    logic turbo;
  } phy_mode_t;

  typedef enum logic {
    KIND_ACK = 1'b0,
    KIND_CTS = 1'b1
  } wait_kind_e;

  localparam int RATE_W = 7;
  localparam int BASE_W = 5;

  function automatic logic [RATE_W-1:0] clk_rate(input phy_mode_t m);
    logic [RATE_W-1:0] r;
    if (m.band5)    r = 7'd40;
    else if (m.cck) r = 7'd22;
    else            r = 7'd44;
    if (m.turbo) r = {r[RATE_W-2:0], 1'b0};
    return r;
  endfunction

  function automatic logic [BASE_W-1:0] slot_base(input phy_mode_t m);
    if (m.turbo)    return 5'd6;
    else if (m.cck) return 5'd20;
    else            return 5'd9;
  endfunction

  function automatic logic [BASE_W-1:0] sifs_base(input phy_mode_t m);
    if (m.turbo)      return 5'd8;
    else if (m.band5) return 5'd16;
    else              return 5'd10;
  endfunction

endpackage

// File: rtl/cct_calc.sv
module cct_calc
  import cct_pkg::*;
#(
  parameter int CC_W = 8,
  parameter int TO_W = 14,
  parameter int US_W = CC_W + 2
) (
  input  phy_mode_t        mode,
  input  logic [CC_W-1:0]  cov_class,
  output logic [US_W-1:0]  slot_us,
  output logic [TO_W-1:0]  to_cyc,
  output logic             fits
);

  localparam int PROD_W    = US_W + RATE_W + 1;
  localparam int FIELD_MAX = (1 << TO_W) - 1;

  logic [RATE_W-1:0] rate;
  logic [US_W-1:0]   cc_x3;
  logic [US_W-1:0]   to_us;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] bound;

  always_comb begin
    rate    = clk_rate(mode);
    cc_x3   = US_W'({cov_class, 1'b0}) + US_W'(cov_class);
    slot_us = US_W'(slot_base(mode)) + cc_x3;
    to_us   = slot_us + US_W'(sifs_base(mode));
    prod    = PROD_W'(to_us) * PROD_W'(rate);
    // floor(MAX/rate) > T  <=>  rate*(T+1) <= MAX
    bound   = prod + PROD_W'(rate);
    fits    = (bound <= PROD_W'(FIELD_MAX));
    to_cyc  = prod[TO_W-1:0];
  end

endmodule

// File: rtl/cct_regs.sv
module cct_regs #(
  parameter int TO_W = 14,
  parameter int US_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [US_W-1:0] slot_in,
  input  logic [TO_W-1:0] cyc_in,
  input  logic            fits,
  output logic [US_W-1:0] slot_q,
  output logic [TO_W-1:0] ack_q,
  output logic [TO_W-1:0] cts_q,
  output logic            err_q
);

  localparam int N_LIM = 2;

  logic [US_W-1:0] slot_d;
  logic            err_d;
  logic            lim_en;
  logic [TO_W-1:0] lim_q [N_LIM];

  always_comb begin
    slot_d = load_en ? slot_in : slot_q;
    err_d  = load_en ? ~fits : err_q;
    lim_en = load_en & fits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      err_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      err_q  <= err_d;
    end
  end

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    logic [TO_W-1:0] lim_d;
    always_comb lim_d = lim_en ? cyc_in : lim_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q[g] <= '0;
      else        lim_q[g] <= lim_d;
    end
  end

  assign ack_q = lim_q[0];
  assign cts_q = lim_q[1];

endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int TO_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_ack,
  input  logic            arm_cts,
  input  logic            rsp,
  input  logic [TO_W-1:0] ack_lim,
  input  logic [TO_W-1:0] cts_lim,
  output logic            busy,
  output logic            to_pulse,
  output logic            to_cts
);

  logic            run_q, run_d;
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic [TO_W-1:0] lim_q, lim_d;
  wait_kind_e      kind_q, kind_d;
  logic            pulse_q, pulse_d;
  logic            tag_q, tag_d;

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    kind_d  = kind_q;
    pulse_d = 1'b0;
    tag_d   = 1'b0;
    if (!run_q) begin
      if (arm_ack && ack_lim != '0) begin
        run_d  = 1'b1;
        cnt_d  = TO_W'(1);
        lim_d  = ack_lim;
        kind_d = KIND_ACK;
      end else if (arm_cts && cts_lim != '0) begin
        run_d  = 1'b1;
        cnt_d  = TO_W'(1);
        lim_d  = cts_lim;
        kind_d = KIND_CTS;
      end
    end else if (rsp) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (cnt_q == lim_q) begin
      run_d   = 1'b0;
      cnt_d   = '0;
      pulse_d = 1'b1;
      tag_d   = (kind_q == KIND_CTS);
    end else begin
      cnt_d = cnt_q + TO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
      kind_q  <= KIND_ACK;
      pulse_q <= 1'b0;
      tag_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      kind_q  <= kind_d;
      pulse_q <= pulse_d;
      tag_q   <= tag_d;
    end
  end

  assign busy     = run_q;
  assign to_pulse = pulse_q;
  assign to_cts   = tag_q;

endmodule

// File: rtl/covcls_timing.sv
module covcls_timing
  import cct_pkg::*;
#(
  parameter int CC_W = 8,
  parameter int TO_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_5g,
  input  logic                mode_cck,
  input  logic                mode_turbo,
  input  logic [CC_W-1:0]     cov_class,
  input  logic                load_i,
  input  logic                tx_ack_i,
  input  logic                tx_cts_i,
  input  logic                rsp_i,
  output logic [CC_W+1:0]     slot_us_o,
  output logic [TO_W-1:0]     ack_cyc_o,
  output logic [TO_W-1:0]     cts_cyc_o,
  output logic                param_err_o,
  output logic                busy_o,
  output logic                timeout_o,
  output logic                timeout_cts_o
);

  localparam int US_W = CC_W + 2;

  phy_mode_t       mode;
  logic [US_W-1:0] calc_slot;
  logic [TO_W-1:0] calc_cyc;
  logic            calc_fits;
  logic            busy;
  logic            load_en;

  always_comb begin
    mode.band5 = mode_5g;
    mode.cck   = mode_cck;
    mode.turbo = mode_turbo;
    load_en    = load_i & ~busy;
  end

  cct_calc #(.CC_W(CC_W), .TO_W(TO_W), .US_W(US_W)) u_calc (
    .mode      (mode),
    .cov_class (cov_class),
    .slot_us   (calc_slot),
    .to_cyc    (calc_cyc),
    .fits      (calc_fits)
  );

  cct_regs #(.TO_W(TO_W), .US_W(US_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .slot_in (calc_slot),
    .cyc_in  (calc_cyc),
    .fits    (calc_fits),
    .slot_q  (slot_us_o),
    .ack_q   (ack_cyc_o),
    .cts_q   (cts_cyc_o),
    .err_q   (param_err_o)
  );

  cct_timer #(.TO_W(TO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_ack  (tx_ack_i),
    .arm_cts  (tx_cts_i),
    .rsp      (rsp_i),
    .ack_lim  (ack_cyc_o),
    .cts_lim  (cts_cyc_o),
    .busy     (busy),
    .to_pulse (timeout_o),
    .to_cts   (timeout_cts_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/covcls_timing_chk.sv
module covcls_timing_chk #(
  parameter int TO_W = 14,
  parameter int US_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            load_i,
  input logic            tx_ack_i,
  input logic            rsp_i,
  input logic [US_W-1:0] slot_us_o,
  input logic [TO_W-1:0] ack_cyc_o,
  input logic [TO_W-1:0] cts_cyc_o,
  input logic            param_err_o,
  input logic            busy_o,
  input logic            timeout_o,
  input logic            timeout_cts_o
);

  assert_cts_matches_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cts_cyc_o == ack_cyc_o);

  assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> (!param_err_o || $stable(ack_cyc_o)));

  assert_busy_blocks_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(slot_us_o) && $stable(ack_cyc_o) && $stable(param_err_o)));

  assert_arm_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && tx_ack_i && ack_cyc_o != '0) |=> busy_o);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  assert_pulse_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($past(busy_o) && !busy_o));

  assert_tag_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_cts_o |-> timeout_o);

  assert_rsp_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rsp_i) |=> (!busy_o && !timeout_o));

endmodule

bind covcls_timing covcls_timing_chk #(.TO_W(TO_W), .US_W(US_W)) u_chk (.*);

// File: tb/covcls_timing_test.sv
module covcls_timing_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam int L616 = 616;

  // {mode 5g/cck/turbo, cov class, slot us, ack cycles, error}
  localparam logic [35:0] VECS [NVEC] = '{
    {3'b100, 8'd0,   10'd9,   14'd1000,  1'b0},
    {3'b010, 8'd0,   10'd20,  14'd660,   1'b0},
    {3'b000, 8'd0,   10'd9,   14'd836,   1'b0},
    {3'b001, 8'd0,   10'd6,   14'd1232,  1'b0},
    {3'b101, 8'd0,   10'd6,   14'd1120,  1'b0},
    {3'b011, 8'd0,   10'd6,   14'd616,   1'b0},
    {3'b110, 8'd0,   10'd20,  14'd1440,  1'b0},
    {3'b100, 8'd127, 10'd390, 14'd16240, 1'b0},
    {3'b100, 8'd128, 10'd393, 14'd16240, 1'b1},
    {3'b000, 8'd10,  10'd39,  14'd2156,  1'b0},
    {3'b001, 8'd255, 10'd771, 14'd2156,  1'b1},
    {3'b010, 8'd237, 10'd731, 14'd16302, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        mode_5g, mode_cck, mode_turbo;
  logic [7:0]  cov_class;
  logic        load_i, tx_ack_i, tx_cts_i, rsp_i;
  logic [9:0]  slot_us_o;
  logic [13:0] ack_cyc_o, cts_cyc_o;
  logic        param_err_o, busy_o, timeout_o, timeout_cts_o;

  int n_chk  = 0;
  int n_fail = 0;

  covcls_timing uut (
    .clk(clk), .rst_n(rst_n),
    .mode_5g(mode_5g), .mode_cck(mode_cck), .mode_turbo(mode_turbo),
    .cov_class(cov_class), .load_i(load_i),
    .tx_ack_i(tx_ack_i), .tx_cts_i(tx_cts_i), .rsp_i(rsp_i),
    .slot_us_o(slot_us_o), .ack_cyc_o(ack_cyc_o), .cts_cyc_o(cts_cyc_o),
    .param_err_o(param_err_o), .busy_o(busy_o),
    .timeout_o(timeout_o), .timeout_cts_o(timeout_cts_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_load(input logic [2:0] m, input logic [7:0] cc);
    @(negedge clk);
    {mode_5g, mode_cck, mode_turbo} = m;
    cov_class = cc;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_arm(input logic a, input logic c);
    @(negedge clk);
    tx_ack_i = a;
    tx_cts_i = c;
    @(negedge clk);
    tx_ack_i = 1'b0;
    tx_cts_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {mode_5g, mode_cck, mode_turbo} = 3'b000;
    cov_class = '0;
    load_i = 0; tx_ack_i = 0; tx_cts_i = 0; rsp_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 slot", slot_us_o, 0);
    chk("R9 ack", ack_cyc_o, 0);
    chk("R9 cts", cts_cyc_o, 0);
    chk("R9 err", param_err_o, 0);
    chk("R9 busy", busy_o, 0);
    chk("R9 timeout", timeout_o, 0);

    // R8 zero limit: arm ignored
    do_arm(1'b1, 1'b0);
    chk("R8 zero-limit busy", busy_o, 0);

    // R1 R2 R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      do_load(VECS[i][35:33], VECS[i][32:25]);
      chk($sformatf("R2 slot vec%0d", i), slot_us_o, int'(VECS[i][24:15]));
      chk($sformatf("R1/R3 ack vec%0d", i), ack_cyc_o, int'(VECS[i][14:1]));
      chk($sformatf("R3 cts vec%0d", i), cts_cyc_o, int'(VECS[i][14:1]));
      chk($sformatf("R4 err vec%0d", i), param_err_o, int'(VECS[i][0]));
    end

    // limit of 616 cycles for timer tests
    do_load(3'b011, 8'd0);
    chk("R3 ack 616", ack_cyc_o, L616);

    // R6 ACK expiry timing
    do_arm(1'b1, 1'b0);
    chk("R6 busy after arm", busy_o, 1);
    repeat (L616 - 1) @(negedge clk);
    chk("R6 no early pulse", timeout_o, 0);
    chk("R6 busy before end", busy_o, 1);
    @(negedge clk);
    chk("R6 pulse", timeout_o, 1);
    chk("R6 ack tag", timeout_cts_o, 0);
    chk("R6 idle at pulse", busy_o, 0);
    @(negedge clk);
    chk("R6 single pulse", timeout_o, 0);

    // R6 CTS tag
    do_arm(1'b0, 1'b1);
    repeat (L616 - 1) @(negedge clk);
    @(negedge clk);
    chk("R6 cts pulse", timeout_o, 1);
    chk("R6 cts tag", timeout_cts_o, 1);

    // R6 both strobes: ACK kind
    do_arm(1'b1, 1'b1);
    repeat (L616) @(negedge clk);
    chk("R6 both pulse", timeout_o, 1);
    chk("R6 both tag ack", timeout_cts_o, 0);

    // R7 response at expiry edge cancels
    do_arm(1'b0, 1'b1);
    repeat (L616 - 1) @(negedge clk);
    rsp_i = 1'b1;
    @(negedge clk);
    rsp_i = 1'b0;
    chk("R7 no pulse at expiry", timeout_o, 0);
    chk("R7 idle after rsp", busy_o, 0);
    repeat (3) @(negedge clk);
    chk("R7 still no pulse", timeout_o, 0);

    // R7 response while idle
    rsp_i = 1'b1;
    @(negedge clk);
    rsp_i = 1'b0;
    chk("R7 idle rsp busy", busy_o, 0);
    chk("R7 idle rsp pulse", timeout_o, 0);

    // R8 arm while busy ignored
    do_arm(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    tx_cts_i = 1'b1;
    @(negedge clk);
    tx_cts_i = 1'b0;
    repeat (L616 - 7) @(negedge clk);
    chk("R8 no early pulse", timeout_o, 0);
    @(negedge clk);
    chk("R8 pulse on time", timeout_o, 1);
    chk("R8 kind kept", timeout_cts_o, 0);
    @(negedge clk);
    chk("R8 no second run", busy_o, 0);

    // R5 load while busy ignored
    do_arm(1'b1, 1'b0);
    {mode_5g, mode_cck, mode_turbo} = 3'b000;
    cov_class = 8'd0;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    chk("R5 slot kept", slot_us_o, 6);
    chk("R5 ack kept", ack_cyc_o, L616);
    repeat (L616 - 2) @(negedge clk);
    @(negedge clk);
    chk("R5 run unaffected", timeout_o, 1);
    do_load(3'b000, 8'd0);
    chk("R5 idle load slot", slot_us_o, 9);
    chk("R5 idle load ack", ack_cyc_o, 836);

    finish_run();
  end

endmodule